// File: doc/BRIEF.md
# Dispatch Slot Accounting Unit

This block is the admission gate of an out-of-order pipeline's dispatch stage. Each clock it looks at one offered instruction and decides whether to take it. The instruction carries a micro-op count and two grouping flags: start-of-group and close-of-group. The block counts the dispatch slots still free in the current dispatch cycle. A dispatch cycle is a window that opens on a clock where `cyc_start` is high, so several instructions offered on consecutive clocks can share one budget of `DISPATCH_W` slots. The block also weighs three readiness inputs: the reorder buffer, the rename register pool and the downstream stage. The block holds no instruction storage. An offer that is not accepted in its own clock must be offered again.

An instruction with more micro-ops than the dispatch width takes every slot of its window. The excess is held in a carry counter and is drained at the following window starts, which reduces the slots left for other instructions. Each acceptance raises an event carrying the micro-ops dispatched in that clock. A separate event reports each drain step of a carried instruction. Every refusal is explained by a stall code.

Top module: `dispatch_slot_unit`

## Requirements
- R1: After reset the unit has `DISPATCH_W` free slots and nothing carried, so an instruction of up to `DISPATCH_W` micro-ops is accepted at once. No event fires and the stall code is 0 while `in_valid` is low.
- R2: On a clock with `cyc_start` high and nothing carried, the free slot count becomes `DISPATCH_W`, and that value already applies to the instruction offered in the same clock.
- R3: An instruction needs min(micro-ops, `DISPATCH_W`) slots. It is refused with stall code 1 (no slots) when zero slots are free, or when it needs more slots than are free. An accepted instruction reduces the free count by its need.
- R4: An instruction with `in_begin_grp` set is accepted only when the free count equals `DISPATCH_W`. Otherwise it is refused with stall code 2 (group wait), provided the slot test of R3 passed.
- R5: Accepting an instruction with `in_end_grp` set leaves zero free slots until the next `cyc_start`.
- R6: Accepting an instruction with micro-ops greater than `DISPATCH_W` leaves zero free slots and sets the carry to micro-ops − `DISPATCH_W`.
- R7: On a `cyc_start` clock with carry c > 0, free slots = 0 if c ≥ `DISPATCH_W`, otherwise `DISPATCH_W` − c. In that same clock `carry_evt_valid` pulses with `carry_evt_uops` = `DISPATCH_W` − free slots, and that amount is subtracted from the carry. No instruction is accepted while the carry occupies every slot.
- R8: Acceptance also requires `in_valid`, `rob_ok`, `regs_ok` and `next_ok` all high. Refusal codes: 3 reorder buffer, 4 register pool, 5 next stage.
- R9: Refusal reasons rank: slots (1), group wait (2), reorder buffer (3), register pool (4), next stage (5). The highest-ranked reason that holds is reported. The code is 0 whenever the instruction is accepted or nothing is offered.
- R10: `disp_evt_valid` pulses in the clock of each acceptance, with `disp_evt_uops` = min(micro-ops, `DISPATCH_W`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | First clock of a new dispatch cycle |
| in_valid | input | 1 | An instruction is offered this clock |
| in_uops | input | 4 | Micro-op count of the offered instruction |
| in_begin_grp | input | 1 | Instruction must open a dispatch group |
| in_end_grp | input | 1 | Instruction closes the dispatch group |
| rob_ok | input | 1 | Reorder buffer can take the micro-ops |
| regs_ok | input | 1 | Rename registers available for all destinations |
| next_ok | input | 1 | Downstream stage ready |
| accept | output | 1 | Offered instruction is taken this clock |
| stall_code | output | 3 | Refusal reason (0 none, 1 slots, 2 group, 3 reorder buffer, 4 registers, 5 next) |
| disp_evt_valid | output | 1 | Acceptance event |
| disp_evt_uops | output | 4 | Micro-ops dispatched by the acceptance |
| carry_evt_valid | output | 1 | Carried-instruction drain event |
| carry_evt_uops | output | 4 | Micro-ops of the carried instruction dispatched this window |

## Verification
The hardest situation to reach is the last drain step of a wide instruction. The carry then leaves only part of the window free, and in that same `cyc_start` clock the carry event fires and a new instruction is judged against the reduced budget. To get there, the stimulus accepts instructions whose micro-op counts are not multiples of the width (for example 10 and 15). It then offers small instructions, and instructions with the start-of-group flag, on every following window start. A behavioural model tracks slots and carry with plain integers and checks all outputs on every clock. It covers both the directed sequences and a long random stretch.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

    localparam int UOP_W = 4;

    typedef logic [UOP_W-1:0] uop_t;

    typedef enum logic [2:0] {
        STALL_NONE  = 3'd0,
        STALL_SLOTS = 3'd1,
        STALL_GROUP = 3'd2,
        STALL_ROB   = 3'd3,
        STALL_REGS  = 3'd4,
        STALL_NEXT  = 3'd5
    } stall_e;

    typedef struct packed {
        uop_t uops;
        logic begin_grp;
        logic end_grp;
    } instr_t;

    typedef struct packed {
        logic valid;
        uop_t uops;
    } evt_t;

    typedef struct packed {
        logic rob;
        logic regs;
        logic nxt;
    } ready_t;

    // slots an instruction occupies in its first window
    function automatic uop_t slot_need(input uop_t uops, input uop_t width);
        return (uops < width) ? uops : width;
    endfunction

    // free slots left once a pending carry takes its share of a window
    function automatic uop_t refill_slots(input uop_t carry, input uop_t width);
        if (carry == '0)
            return width;
        return (carry >= width) ? uop_t'(0) : uop_t'(width - carry);
    endfunction

endpackage

// File: rtl/dsa_refill.sv
module dsa_refill
    import dsa_pkg::*;
#(
    parameter int DISPATCH_W = 4
) (
    input  logic cyc_start,
    input  uop_t avail_q,
    input  uop_t carry_q,
    output uop_t eff_avail,
    output uop_t eff_carry,
    output evt_t carry_evt
);
    localparam uop_t WV = uop_t'(DISPATCH_W);

    always_comb begin
        eff_avail = avail_q;
        eff_carry = carry_q;
        carry_evt = '0;
        if (cyc_start) begin
            eff_avail = refill_slots(carry_q, WV);
            if (carry_q != '0) begin
                carry_evt.valid = 1'b1;
                carry_evt.uops  = WV - eff_avail;
                eff_carry       = carry_q - (WV - eff_avail);
            end
        end
    end
endmodule

// File: rtl/dsa_admit.sv
module dsa_admit
    import dsa_pkg::*;
#(
    parameter int DISPATCH_W = 4
) (
    input  logic   in_valid,
    input  instr_t instr,
    input  ready_t rdy,
    input  uop_t   eff_avail,
    output logic   accept,
    output stall_e stall,
    output uop_t   need
);
    localparam uop_t WV = uop_t'(DISPATCH_W);

    logic slots_short;
    logic group_block;

    always_comb begin
        need        = slot_need(instr.uops, WV);
        slots_short = (eff_avail == '0) || (need > eff_avail);
        group_block = instr.begin_grp && (eff_avail != WV);

        stall = STALL_NONE;
        if (in_valid) begin
            if (slots_short)
                stall = STALL_SLOTS;
            else if (group_block)
                stall = STALL_GROUP;
            else if (!rdy.rob)
                stall = STALL_ROB;
            else if (!rdy.regs)
                stall = STALL_REGS;
            else if (!rdy.nxt)
                stall = STALL_NEXT;
        end
        accept = in_valid && (stall == STALL_NONE);
    end
endmodule

// File: rtl/dsa_state.sv
module dsa_state
    import dsa_pkg::*;
#(
    parameter int DISPATCH_W = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   accept,
    input  instr_t instr,
    input  uop_t   need,
    input  uop_t   eff_avail,
    input  uop_t   eff_carry,
    output uop_t   avail_q,
    output uop_t   carry_q
);
    localparam uop_t WV = uop_t'(DISPATCH_W);

    uop_t avail_d;
    uop_t carry_d;

    always_comb begin
        avail_d = eff_avail;
        carry_d = eff_carry;
        if (accept) begin
            if (instr.uops > WV) begin
                avail_d = '0;
                carry_d = instr.uops - WV;
            end else begin
                avail_d = eff_avail - need;
            end
            if (instr.end_grp)
                avail_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            avail_q <= WV;
            carry_q <= '0;
        end else begin
            avail_q <= avail_d;
            carry_q <= carry_d;
        end
    end
endmodule

// File: rtl/dispatch_slot_unit.sv
module dispatch_slot_unit
    import dsa_pkg::*;
#(
    parameter int DISPATCH_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_start,
    input  logic             in_valid,
    input  logic [UOP_W-1:0] in_uops,
    input  logic             in_begin_grp,
    input  logic             in_end_grp,
    input  logic             rob_ok,
    input  logic             regs_ok,
    input  logic             next_ok,
    output logic             accept,
    output logic [2:0]       stall_code,
    output logic             disp_evt_valid,
    output logic [UOP_W-1:0] disp_evt_uops,
    output logic             carry_evt_valid,
    output logic [UOP_W-1:0] carry_evt_uops
);
    generate
        if (DISPATCH_W < 1 || DISPATCH_W >= (1 << UOP_W)) begin : g_bad_width
            $error("dispatch_slot_unit: DISPATCH_W out of range");
        end
    endgenerate

    instr_t instr;
    ready_t rdy;
    uop_t   avail_q, carry_q;
    uop_t   eff_avail, eff_carry, need;
    evt_t   carry_evt;
    stall_e stall;

    assign instr = '{uops: in_uops, begin_grp: in_begin_grp, end_grp: in_end_grp};
    assign rdy   = '{rob: rob_ok, regs: regs_ok, nxt: next_ok};

    dsa_refill #(.DISPATCH_W(DISPATCH_W)) refill_i (
        .cyc_start (cyc_start),
        .avail_q   (avail_q),
        .carry_q   (carry_q),
        .eff_avail (eff_avail),
        .eff_carry (eff_carry),
        .carry_evt (carry_evt)
    );

    dsa_admit #(.DISPATCH_W(DISPATCH_W)) admit_i (
        .in_valid  (in_valid),
        .instr     (instr),
        .rdy       (rdy),
        .eff_avail (eff_avail),
        .accept    (accept),
        .stall     (stall),
        .need      (need)
    );

    dsa_state #(.DISPATCH_W(DISPATCH_W)) state_i (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .instr     (instr),
        .need      (need),
        .eff_avail (eff_avail),
        .eff_carry (eff_carry),
        .avail_q   (avail_q),
        .carry_q   (carry_q)
    );

    assign stall_code      = stall;
    assign disp_evt_valid  = accept;
    assign disp_evt_uops   = accept ? need : '0;
    assign carry_evt_valid = carry_evt.valid;
    assign carry_evt_uops  = carry_evt.uops;
endmodule

// File: rtl/dispatch_slot_unit_chk.sv
module dispatch_slot_unit_chk
    import dsa_pkg::*;
#(
    parameter int DISPATCH_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             cyc_start,
    input logic             in_valid,
    input logic [UOP_W-1:0] in_uops,
    input logic             in_begin_grp,
    input logic             in_end_grp,
    input logic             rob_ok,
    input logic             regs_ok,
    input logic             next_ok,
    input logic             accept,
    input logic [2:0]       stall_code,
    input logic             disp_evt_uops_ok,
    input logic             carry_evt_valid,
    input logic [UOP_W-1:0] carry_evt_uops,
    input logic [UOP_W-1:0] avail_q,
    input logic [UOP_W-1:0] carry_q
);
    localparam logic [UOP_W-1:0] WV = UOP_W'(DISPATCH_W);

    p_ready_gate_r8: assert property (@(posedge clk) disable iff (rst)
        accept |-> (in_valid && rob_ok && regs_ok && next_ok));

    p_code_clear_r9: assert property (@(posedge clk) disable iff (rst)
        accept |-> (stall_code == 3'd0));

    p_code_set_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !accept) |-> (stall_code != 3'd0));

    p_carry_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        (carry_q != '0 && !cyc_start) |-> !accept);

    p_carry_full_r7: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && carry_q >= WV) |-> !accept);

    p_carry_evt_range_r7: assert property (@(posedge clk) disable iff (rst)
        carry_evt_valid |-> (carry_evt_uops != '0 && carry_evt_uops <= WV));

    p_end_closes_r5: assert property (@(posedge clk) disable iff (rst)
        (accept && in_end_grp) |=> (cyc_start || !accept));

    p_wide_carry_r6: assert property (@(posedge clk) disable iff (rst)
        (accept && in_uops > WV) |=> (carry_q == $past(in_uops) - WV && avail_q == '0));

    p_begin_full_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && in_begin_grp && !cyc_start) |-> (avail_q == WV));

    p_evt_bound_r10: assert property (@(posedge clk) disable iff (rst)
        disp_evt_uops_ok);
endmodule

bind dispatch_slot_unit dispatch_slot_unit_chk #(.DISPATCH_W(DISPATCH_W)) chk_i (
    .clk              (clk),
    .rst              (rst),
    .cyc_start        (cyc_start),
    .in_valid         (in_valid),
    .in_uops          (in_uops),
    .in_begin_grp     (in_begin_grp),
    .in_end_grp       (in_end_grp),
    .rob_ok           (rob_ok),
    .regs_ok          (regs_ok),
    .next_ok          (next_ok),
    .accept           (accept),
    .stall_code       (stall_code),
    .disp_evt_uops_ok (!disp_evt_valid || (disp_evt_uops <= in_uops && disp_evt_uops <= DISPATCH_W)),
    .carry_evt_valid  (carry_evt_valid),
    .carry_evt_uops   (carry_evt_uops),
    .avail_q          (avail_q),
    .carry_q          (carry_q)
);

// File: tb/dispatch_slot_unit_tb_top.sv
module dispatch_slot_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_start = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] in_uops = '0;
    logic       in_begin_grp = 1'b0;
    logic       in_end_grp = 1'b0;
    logic       rob_ok = 1'b1;
    logic       regs_ok = 1'b1;
    logic       next_ok = 1'b1;
    logic       accept;
    logic [2:0] stall_code;
    logic       disp_evt_valid;
    logic [3:0] disp_evt_uops;
    logic       carry_evt_valid;
    logic [3:0] carry_evt_uops;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // behavioural model state
    int m_avail = W;
    int m_carry = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dispatch_slot_unit #(.DISPATCH_W(W)) dut_i (
        .clk (clk), .rst (rst), .cyc_start (cyc_start), .in_valid (in_valid),
        .in_uops (in_uops), .in_begin_grp (in_begin_grp), .in_end_grp (in_end_grp),
        .rob_ok (rob_ok), .regs_ok (regs_ok), .next_ok (next_ok),
        .accept (accept), .stall_code (stall_code),
        .disp_evt_valid (disp_evt_valid), .disp_evt_uops (disp_evt_uops),
        .carry_evt_valid (carry_evt_valid), .carry_evt_uops (carry_evt_uops)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // one clock: drive, compare with the model, advance the model
    task automatic step(input string tag, input bit v, input int u, input bit bg,
                        input bit eg, input bit rb, input bit rg, input bit nx,
                        input bit cs);
        int  av, cr, need, code, ce_u, de_u;
        bit  acc, ce_v;
        cyc_start = cs; in_valid = v; in_uops = 4'(u); in_begin_grp = bg;
        in_end_grp = eg; rob_ok = rb; regs_ok = rg; next_ok = nx;
        #2;
        av = m_avail; cr = m_carry; ce_v = 1'b0; ce_u = 0;
        if (cs) begin
            if (m_carry == 0) av = W;
            else begin
                av = (m_carry >= W) ? 0 : W - m_carry;
                ce_v = 1'b1; ce_u = W - av; cr = m_carry - ce_u;
            end
        end
        need = (u < W) ? u : W;
        code = 0;
        if (v) begin
            if (av == 0 || need > av) code = 1;
            else if (bg && av != W) code = 2;
            else if (!rb) code = 3;
            else if (!rg) code = 4;
            else if (!nx) code = 5;
        end
        acc  = v && code == 0;
        de_u = acc ? need : 0;
        checks++;
        if (accept !== acc || stall_code !== 3'(code) || disp_evt_valid !== acc ||
            disp_evt_uops !== 4'(de_u) || carry_evt_valid !== ce_v ||
            carry_evt_uops !== 4'(ce_u)) begin
            failures++;
            $display("FAIL %s: actual acc=%0b code=%0d ev=%0b/%0d cev=%0b/%0d expected acc=%0b code=%0d ev=%0b/%0d cev=%0b/%0d",
                     tag, accept, stall_code, disp_evt_valid, disp_evt_uops,
                     carry_evt_valid, carry_evt_uops, acc, code, acc, de_u, ce_v, ce_u);
        end
        @(posedge clk);
        if (acc) begin
            if (u > W) begin m_avail = 0; m_carry = u - W; end
            else begin m_avail = av - need; m_carry = cr; end
            if (eg) m_avail = 0;
        end else begin
            m_avail = av; m_carry = cr;
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: idle after reset, then full budget
        step("R1 idle",        0, 0, 0,0,1,1,1, 0);
        step("R1 full",        1, 4, 0,0,1,1,1, 0);
        step("R3 empty",       1, 1, 0,0,1,1,1, 0);
        // R2 / R3 partial budget
        step("R2 refill",      1, 2, 0,0,1,1,1, 1);
        step("R3 too big",     1, 3, 0,0,1,1,1, 0);
        step("R3 fits",        1, 2, 0,0,1,1,1, 0);
        // R4 begin-group
        step("R2 refill",      1, 1, 0,0,1,1,1, 1);
        step("R4 not first",   1, 1, 1,0,1,1,1, 0);
        step("R4 first",       1, 2, 1,0,1,1,1, 1);
        // R5 end-group
        step("R5 close",       1, 1, 0,1,1,1,1, 1);
        step("R5 closed",      1, 1, 0,0,1,1,1, 0);
        step("R5 reopen",      1, 1, 0,0,1,1,1, 1);
        // R8 / R9 readiness and priority
        step("R8 rob",         1, 1, 0,0,0,1,1, 1);
        step("R8 regs",        1, 1, 0,0,1,0,1, 0);
        step("R8 next",        1, 1, 0,0,1,1,0, 0);
        step("R9 all low",     1, 1, 0,0,0,0,0, 0);
        step("R9 regs+next",   1, 1, 0,0,1,0,0, 0);
        step("R9 slots first", 1, 9, 1,0,0,0,0, 0);
        step("R10 evt",        1, 3, 0,0,1,1,1, 1);
        // R6 / R7 wide instruction with partial last step
        step("R6 wide",        1,10, 0,0,1,1,1, 1);
        step("R6 no slots",    1, 1, 0,0,1,1,1, 0);
        step("R7 drain full",  1, 1, 0,0,1,1,1, 1);
        step("R7 drain tail",  1, 2, 0,0,1,1,1, 1);
        step("R7 begin busy",  1, 1, 1,0,1,1,1, 0);
        step("R7 idle",        0, 0, 0,0,1,1,1, 1);
        step("R6 widest",      1,15, 0,0,1,1,1, 1);
        for (int k = 0; k < 4; k++)
            step("R7 drain",   1, 1, 1,0,1,1,1, 1);
        step("R2 after drain", 1, 4, 1,0,1,1,1, 1);
        step("R1 zero uops",   1, 0, 0,0,1,1,1, 1);
        for (int k = 0; k < 600; k++)
            step("R3 random", 1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 15)),
                 1'($urandom_range(0, 4) == 0), 1'($urandom_range(0, 4) == 0),
                 1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 7) != 0),
                 1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 2) == 0));
        finish_run();
    end
endmodule